// File: doc/BRIEF.md
# Strip Stave Operating-Phase Manager

This block sequences one strip stave through its four operating phases: pre-operation, controller ramp (the stave-end controller card is powered and optical communication is brought up), module ramp and run. Each phase step is taken only on a request from the control system. A request counts only when cooling is running, the cooling interlock is quiet, the module temperature interlock is armed and it is not tripped. From the phase and the powering scheme the block drives the stave power enables: controller-card power, front-end low voltage, high voltage, the per-module power enables and the per-module bypass controls.

While the stave is out of pre-operation the block watches for two kinds of failure. A cooling failure is cooling stopping or the cooling interlock tripping. A module temperature failure is the module interlock tripping or being disarmed. A cooling failure removes every power output in either powering scheme. A module temperature failure drops front-end low voltage and high voltage under serial powering, and drops only the per-module enables under DC-DC powering. The failure is recorded in a two-bit cause register. The phase is frozen until software clears that register. The clear returns the stave to pre-operation, so the full advance sequence has to be repeated.

Top module: `stave_phase_ctrl`

## Requirements
- R1: After reset, phase_o is 0 (pre-operation), cause_o is 0 and every power output is 0.
- R2: Phase codes are 0 pre-operation, 1 controller ramp, 2 module ramp, 3 run. Each accepted advance raises the phase by exactly one. An advance in phase 3 leaves the phase at 3.
- R3: An advance is accepted only when cool_on=1, cool_trip=0, mod_ilk_armed=1 and mod_trip=0 and no cause is latched. Otherwise phase_o is unchanged.
- R4: In phase 0 every power output is 0. Interlock inputs seen in phase 0 latch no cause.
- R5: Without a latched cause, ctrl_pwr_en is 1 in phases 1 to 3, fe_lv_en is 1 in phases 2 and 3, and hv_en is 1 only in phase 3.
- R6: In phases 2 and 3 without a latched cause, serial powering (dcdc_mode=0) gives mod_bypass=byp_req and mod_pwr_en=0. DC-DC powering (dcdc_mode=1) gives mod_pwr_en=mod_sel and mod_bypass=0.
- R7: In phases 1 to 3, cool_on=0 or cool_trip=1 sets cause_o bit 0 at the next edge. From then on every power output is 0 in both powering schemes.
- R8: In phases 1 to 3 under serial powering, mod_trip=1 or mod_ilk_armed=0 sets cause_o bit 1 at the next edge. This drops fe_lv_en and hv_en while ctrl_pwr_en and mod_bypass are kept.
- R9: The same module failure under DC-DC powering sets cause_o bit 1 and drops only mod_pwr_en. ctrl_pwr_en, fe_lv_en and hv_en keep their phase values.
- R10: While cause_o is non-zero the phase holds and advances are ignored. Further failures add their cause bits.
- R11: cause_clr=1 with a non-zero cause and no failure condition present clears cause_o and returns the phase to 0 at the next edge.
- R12: A clear while a failure condition is still present leaves that condition's cause bit set and the phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dcdc_mode | input | 1 | Powering scheme: 0 serial, 1 DC-DC |
| cool_on | input | 1 | Cooling plant running |
| cool_trip | input | 1 | Cooling interlock tripped |
| mod_ilk_armed | input | 1 | Module temperature interlock armed |
| mod_trip | input | 1 | Module temperature interlock tripped |
| adv_req | input | 1 | Request to step to the next phase |
| cause_clr | input | 1 | Software clear of the failure cause |
| mod_sel | input | N_MOD | Per-module power request (DC-DC) |
| byp_req | input | N_MOD | Per-module bypass request (serial) |
| phase_o | output | 2 | Current phase code |
| cause_o | output | 2 | Latched cause: bit 0 cooling, bit 1 module temperature |
| ctrl_pwr_en | output | 1 | Controller card power enable |
| fe_lv_en | output | 1 | Front-end low voltage enable |
| hv_en | output | 1 | High voltage enable |
| mod_pwr_en | output | N_MOD | Per-module power enables |
| mod_bypass | output | N_MOD | Per-module bypass controls |

## Verification
Phase and cause are single registers, and every power output is decoded from them without further storage. A stimulus applied before an edge therefore shows on phase_o, cause_o and the power outputs right after that edge. dcdc_mode, mod_sel and byp_req reach the outputs in the same cycle. The bench drives each vector 1 ns after a rising edge and compares 1 ns after the following rising edge, so every result is read exactly one edge after its cause. The assertions use the same one-edge relation through |=>.

// File: rtl/stave_phase_pkg.sv
package stave_phase_pkg;

  typedef enum logic [1:0] {
    PH_PREOP     = 2'd0,
    PH_CTRL_RAMP = 2'd1,
    PH_MOD_RAMP  = 2'd2,
    PH_RUN       = 2'd3
  } phase_e;

  localparam int CAUSE_W    = 2;
  localparam int CAUSE_COOL = 0;
  localparam int CAUSE_MOD  = 1;

  // Conditions every phase above pre-operation requires.
  function automatic logic phase_gate_ok(input logic cool_on, input logic cool_trip,
                                         input logic armed, input logic mod_trip);
    return cool_on && !cool_trip && armed && !mod_trip;
  endfunction

  function automatic phase_e phase_step(input phase_e p);
    case (p)
      PH_PREOP:     return PH_CTRL_RAMP;
      PH_CTRL_RAMP: return PH_MOD_RAMP;
      default:      return PH_RUN;
    endcase
  endfunction

  function automatic logic phase_is_module(input phase_e p);
    return (p == PH_MOD_RAMP) || (p == PH_RUN);
  endfunction

endpackage

// File: rtl/stave_phase_seq.sv
module stave_phase_seq
  import stave_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv_req,
  input  logic   gate_ok,
  input  logic   held,
  input  logic   fault_any,
  input  logic   clr_fire,
  output phase_e phase,
  output logic   adv_ok
);

  assign adv_ok = adv_req && gate_ok && !held && !fault_any && (phase != PH_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n)        phase <= PH_PREOP;
    else if (clr_fire) phase <= PH_PREOP;
    else if (adv_ok)   phase <= phase_step(phase);
  end

endmodule

// File: rtl/stave_fault_latch.sv
module stave_fault_latch
  import stave_phase_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase,
  input  logic               cool_on,
  input  logic               cool_trip,
  input  logic               armed,
  input  logic               mod_trip,
  input  logic               cause_clr,
  output logic [CAUSE_W-1:0] cause,
  output logic               fault_cool,
  output logic               fault_mod,
  output logic               held,
  output logic               clr_fire
);

  logic               active;
  logic [CAUSE_W-1:0] new_bits;

  assign active     = (phase != PH_PREOP);
  assign fault_cool = active && (!cool_on || cool_trip);
  assign fault_mod  = active && (!armed || mod_trip);
  assign held       = (cause != '0);
  assign clr_fire   = cause_clr && held && !fault_cool && !fault_mod;

  always_comb begin
    new_bits             = '0;
    new_bits[CAUSE_COOL] = fault_cool;
    new_bits[CAUSE_MOD]  = fault_mod;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause <= '0;
    else        cause <= (cause_clr ? '0 : cause) | new_bits;
  end

endmodule

// File: rtl/stave_power_map.sv
module stave_power_map
  import stave_phase_pkg::*;
#(
  parameter int N_MOD = 12
) (
  input  phase_e             phase,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               dcdc_mode,
  input  logic [N_MOD-1:0]   mod_sel,
  input  logic [N_MOD-1:0]   byp_req,
  output logic               ctrl_pwr_en,
  output logic               fe_lv_en,
  output logic               hv_en,
  output logic [N_MOD-1:0]   mod_pwr_en,
  output logic [N_MOD-1:0]   mod_bypass
);

  logic cool_kill;
  logic fe_kill;
  logic mod_kill;
  logic mod_phase;
  logic pwr_lane_on;
  logic byp_lane_on;

  assign cool_kill   = cause[CAUSE_COOL];
  assign fe_kill     = cool_kill || (cause[CAUSE_MOD] && !dcdc_mode);
  assign mod_kill    = cool_kill || cause[CAUSE_MOD];
  assign mod_phase   = phase_is_module(phase);

  assign ctrl_pwr_en = (phase != PH_PREOP) && !cool_kill;
  assign fe_lv_en    = mod_phase && !fe_kill;
  assign hv_en       = (phase == PH_RUN) && !fe_kill;
  assign pwr_lane_on = mod_phase && dcdc_mode && !mod_kill;
  assign byp_lane_on = mod_phase && !dcdc_mode && !cool_kill;

  for (genvar i = 0; i < N_MOD; i++) begin : g_lane
    assign mod_pwr_en[i] = pwr_lane_on && mod_sel[i];
    assign mod_bypass[i] = byp_lane_on && byp_req[i];
  end

endmodule

// File: rtl/stave_phase_ctrl.sv
module stave_phase_ctrl
  import stave_phase_pkg::*;
#(
  parameter int N_MOD = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dcdc_mode,
  input  logic               cool_on,
  input  logic               cool_trip,
  input  logic               mod_ilk_armed,
  input  logic               mod_trip,
  input  logic               adv_req,
  input  logic               cause_clr,
  input  logic [N_MOD-1:0]   mod_sel,
  input  logic [N_MOD-1:0]   byp_req,
  output logic [1:0]         phase_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               ctrl_pwr_en,
  output logic               fe_lv_en,
  output logic               hv_en,
  output logic [N_MOD-1:0]   mod_pwr_en,
  output logic [N_MOD-1:0]   mod_bypass
);

  phase_e             phase;
  logic [CAUSE_W-1:0] cause;
  logic               gate_ok;
  logic               adv_ok;
  logic               fault_cool;
  logic               fault_mod;
  logic               held;
  logic               clr_fire;

  assign gate_ok = phase_gate_ok(cool_on, cool_trip, mod_ilk_armed, mod_trip);

  stave_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv_req   (adv_req),
    .gate_ok   (gate_ok),
    .held      (held),
    .fault_any (fault_cool || fault_mod),
    .clr_fire  (clr_fire),
    .phase     (phase),
    .adv_ok    (adv_ok)
  );

  stave_fault_latch u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .cool_on    (cool_on),
    .cool_trip  (cool_trip),
    .armed      (mod_ilk_armed),
    .mod_trip   (mod_trip),
    .cause_clr  (cause_clr),
    .cause      (cause),
    .fault_cool (fault_cool),
    .fault_mod  (fault_mod),
    .held       (held),
    .clr_fire   (clr_fire)
  );

  stave_power_map #(.N_MOD(N_MOD)) u_map (
    .phase       (phase),
    .cause       (cause),
    .dcdc_mode   (dcdc_mode),
    .mod_sel     (mod_sel),
    .byp_req     (byp_req),
    .ctrl_pwr_en (ctrl_pwr_en),
    .fe_lv_en    (fe_lv_en),
    .hv_en       (hv_en),
    .mod_pwr_en  (mod_pwr_en),
    .mod_bypass  (mod_bypass)
  );

  assign phase_o = phase;
  assign cause_o = cause;

endmodule

// File: rtl/stave_phase_chk.sv
module stave_phase_chk #(
  parameter int N_MOD = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dcdc_mode,
  input logic             cool_on,
  input logic             cool_trip,
  input logic             mod_ilk_armed,
  input logic             mod_trip,
  input logic             adv_req,
  input logic             cause_clr,
  input logic [1:0]       phase,
  input logic [1:0]       cause,
  input logic             ctrl_pwr_en,
  input logic             fe_lv_en,
  input logic             hv_en,
  input logic [N_MOD-1:0] mod_pwr_en,
  input logic [N_MOD-1:0] mod_bypass,
  input logic             adv_ok,
  input logic             fault_cool,
  input logic             fault_mod
);

  logic conds_good;
  assign conds_good = cool_on && !cool_trip && mod_ilk_armed && !mod_trip;

  // R2: an accepted advance moves the phase up by one
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_req && conds_good && cause == 2'd0 && phase != 2'd3) |=> phase == $past(phase) + 2'd1);

  // R3: without a valid request and without a clear the phase does not move
  p_adv_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(adv_req && conds_good) && !cause_clr) |=> phase == $past(phase));

  // R3: the sequencer only accepts when the gate conditions hold
  p_adv_ok_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ok |-> conds_good);

  // R4: pre-operation keeps every power output off
  p_preop_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0) |-> (!ctrl_pwr_en && !fe_lv_en && !hv_en && mod_pwr_en == '0 && mod_bypass == '0));

  // R7: a cooling failure removes all power at the next edge
  p_cool_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_cool |=> (cause[0] && !ctrl_pwr_en && !fe_lv_en && !hv_en && mod_pwr_en == '0 && mod_bypass == '0));

  // R8: serial module failure inhibits front-end low and high voltage
  p_serial_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mod && !dcdc_mode) |=> (dcdc_mode || (cause[1] && !fe_lv_en && !hv_en)));

  // R9: DC-DC module failure drops the per-module enables
  p_dcdc_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mod && dcdc_mode) |=> (!dcdc_mode || (cause[1] && mod_pwr_en == '0)));

  // R10: a latched cause freezes the phase
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 2'd0 && !cause_clr) |=> phase == $past(phase));

  // R11: a clean clear returns to pre-operation
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause != 2'd0 && cause_clr && !fault_cool && !fault_mod) |=> (phase == 2'd0 && cause == 2'd0));

endmodule

bind stave_phase_ctrl stave_phase_chk #(.N_MOD(N_MOD)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dcdc_mode     (dcdc_mode),
  .cool_on       (cool_on),
  .cool_trip     (cool_trip),
  .mod_ilk_armed (mod_ilk_armed),
  .mod_trip      (mod_trip),
  .adv_req       (adv_req),
  .cause_clr     (cause_clr),
  .phase         (phase_o),
  .cause         (cause_o),
  .ctrl_pwr_en   (ctrl_pwr_en),
  .fe_lv_en      (fe_lv_en),
  .hv_en         (hv_en),
  .mod_pwr_en    (mod_pwr_en),
  .mod_bypass    (mod_bypass),
  .adv_ok        (adv_ok),
  .fault_cool    (fault_cool),
  .fault_mod     (fault_mod)
);

// File: tb/stave_phase_ctrl_tb.sv
module stave_phase_ctrl_tb;

  localparam int N = 12;
  localparam logic [N-1:0] SEL = 12'hA5C;
  localparam logic [N-1:0] BYP = 12'h3C3;
  localparam int ROWS = 23;

  // Row: [14:11] requirement, [10:4] {dcdc,cool_on,cool_trip,armed,mod_trip,adv,clr},
  //      [3:2] expected phase, [1:0] expected cause
  localparam logic [14:0] TBL [ROWS] = '{
    {4'd3,  7'b0001010, 2'd0, 2'd0},  // R3 cooling off blocks advance
    {4'd3,  7'b0100010, 2'd0, 2'd0},  // R3 interlock not armed blocks advance
    {4'd3,  7'b0101000, 2'd0, 2'd0},  // R3 no request, no move
    {4'd5,  7'b0101010, 2'd1, 2'd0},  // R5 controller ramp
    {4'd6,  7'b0101010, 2'd2, 2'd0},  // R6 serial bypass lanes
    {4'd5,  7'b0101010, 2'd3, 2'd0},  // R5 run
    {4'd2,  7'b0101010, 2'd3, 2'd0},  // R2 saturates at run
    {4'd8,  7'b0101100, 2'd3, 2'd2},  // R8 serial module failure
    {4'd10, 7'b0101010, 2'd3, 2'd2},  // R10 advance ignored while held
    {4'd12, 7'b0101101, 2'd3, 2'd2},  // R12 clear with trip still present
    {4'd10, 7'b0111000, 2'd3, 2'd3},  // R10 cooling cause accumulates
    {4'd11, 7'b0101001, 2'd0, 2'd0},  // R11 clean clear
    {4'd11, 7'b0101010, 2'd1, 2'd0},  // R11 fresh sequence
    {4'd6,  7'b1101010, 2'd2, 2'd0},  // R6 DC-DC module enables
    {4'd9,  7'b1101100, 2'd2, 2'd2},  // R9 DC-DC module failure
    {4'd11, 7'b1101001, 2'd0, 2'd0},  // R11 clean clear
    {4'd2,  7'b1101010, 2'd1, 2'd0},  // R2 step
    {4'd2,  7'b1101010, 2'd2, 2'd0},  // R2 step
    {4'd6,  7'b1101010, 2'd3, 2'd0},  // R6 DC-DC in run
    {4'd7,  7'b1001000, 2'd3, 2'd1},  // R7 cooling stops
    {4'd12, 7'b1001001, 2'd3, 2'd1},  // R12 clear while cooling still off
    {4'd11, 7'b1101001, 2'd0, 2'd0},  // R11 clean clear
    {4'd4,  7'b1100000, 2'd0, 2'd0}   // R4 disarm in pre-operation latches nothing
  };

  logic clk = 1'b0;
  logic rst_n;
  logic dcdc_mode, cool_on, cool_trip, mod_ilk_armed, mod_trip, adv_req, cause_clr;
  logic [N-1:0] mod_sel, byp_req;
  logic [1:0] phase_o, cause_o;
  logic ctrl_pwr_en, fe_lv_en, hv_en;
  logic [N-1:0] mod_pwr_en, mod_bypass;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stave_phase_ctrl #(.N_MOD(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .dcdc_mode(dcdc_mode), .cool_on(cool_on),
    .cool_trip(cool_trip), .mod_ilk_armed(mod_ilk_armed), .mod_trip(mod_trip),
    .adv_req(adv_req), .cause_clr(cause_clr), .mod_sel(mod_sel), .byp_req(byp_req),
    .phase_o(phase_o), .cause_o(cause_o), .ctrl_pwr_en(ctrl_pwr_en),
    .fe_lv_en(fe_lv_en), .hv_en(hv_en), .mod_pwr_en(mod_pwr_en), .mod_bypass(mod_bypass)
  );

  // Expected power outputs restated from R4 to R9: {ctrl, fe_lv, hv, mod_pwr_en, mod_bypass}
  function automatic logic [2*N+2:0] expect_pwr(input logic [1:0] ph, input logic [1:0] c,
                                                input logic dc);
    logic cool_off, fe_off, modph;
    logic [N-1:0] mp, bp;
    cool_off = c[0];
    fe_off   = cool_off || (c[1] && !dc);
    modph    = (ph >= 2'd2);
    mp = (dc && modph && c == 2'd0) ? SEL : '0;
    bp = (!dc && modph && !cool_off) ? BYP : '0;
    return {(ph != 2'd0) && !cool_off, modph && !fe_off, (ph == 2'd3) && !fe_off, mp, bp};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input int req, input logic [1:0] ph, input logic [1:0] c);
    logic [2*N+2:0] e;
    e = expect_pwr(ph, c, dcdc_mode);
    check(req, "phase", 32'(phase_o), 32'(ph));
    check(req, "cause", 32'(cause_o), 32'(c));
    check(req, "enables", 32'({ctrl_pwr_en, fe_lv_en, hv_en}), 32'(e[2*N+2:2*N]));
    check(req, "module power", 32'(mod_pwr_en), 32'(e[2*N-1:N]));
    check(req, "bypass", 32'(mod_bypass), 32'(e[N-1:0]));
  endtask

  task automatic drive(input logic [6:0] s);
    {dcdc_mode, cool_on, cool_trip, mod_ilk_armed, mod_trip, adv_req, cause_clr} = s;
  endtask

  task automatic step(input logic [6:0] s);
    drive(s);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mod_sel = SEL;
    byp_req = BYP;
    drive(7'b0101010);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, with advance requested during reset
    check_state(1, 2'd0, 2'd0);
    rst_n = 1'b1;

    for (int i = 0; i < ROWS; i++) begin
      step(TBL[i][10:4]);
      check_state(int'(TBL[i][14:11]), TBL[i][3:2], TBL[i][1:0]);
    end

    // R4: cooling trip and clear in pre-operation leave everything off
    step(7'b0110001);
    check_state(4, 2'd0, 2'd0);

    // R1: reset from run returns to pre-operation
    step(7'b0101010);
    step(7'b0101010);
    step(7'b0101010);
    check_state(2, 2'd3, 2'd0);
    rst_n = 1'b0;
    step(7'b0101000);
    check_state(1, 2'd0, 2'd0);
    rst_n = 1'b1;

    // R6: serial mode with a different bypass pattern follows the request
    step(7'b0101010);
    step(7'b0101010);
    byp_req = 12'h00F;
    #1;
    check(6, "bypass pattern", 32'(mod_bypass), 32'(12'h00F));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule